// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block holds the eight interrupt flags of a group of three timer/counters, together with an eight-bit per-source enable register and a global interrupt enable input. Single-cycle event pulses from the timers set the flags. The timers report compare match, overflow and input capture; the counters themselves sit outside this block. Software reads both registers at any time. It clears a flag by writing a one to its bit, and a zero in the written value leaves that flag alone. A write to the enable register replaces its whole contents.

The block ANDs each flag with its enable and with the global enable to form one request per source. A priority encoder turns the pending requests into a vector offer: `irq_valid` with the index `irq_idx`. Index 0 has the highest priority and maps to the most significant flag bit. The CPU takes the offer by pulsing `ack_valid` with the index it is servicing, and that pulse clears only the matching flag. The offer is not held stable while it waits: if a higher-priority source becomes pending before the acknowledge, `irq_idx` moves to it. An acknowledge never stalls, and an acknowledge for a flag that is already clear has no effect. The timer-2 overflow flag has a second set source. While `t2_dual_slope` is high, that flag is set by the counter's turnaround at the bottom (`t2_turn_evt`) and not by the wrap pulse.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, `flags_rd`, `enables_rd` and `irq_req` are all zero and `irq_valid` is low.
- R2: The flag bits run from bit 7 down to bit 0 as timer2 compare, timer2 overflow, timer1 capture, timer1 compare A, timer1 compare B, timer1 overflow, timer0 compare and timer0 overflow. A pulse on `evt_set[b]` makes `flags_rd[b]` one from the next clock edge on. Bit 6 is the exception and follows R8.
- R3: A write with `reg_we`=1 and `reg_sel`=0 (flag register) clears every flag whose `reg_wdata` bit is one. Flags whose written bit is zero keep their value.
- R4: A pulse on `ack_valid` with `ack_idx`=i clears flag bit 7-i at the next edge and no other flag.
- R5: If a set event lands on the same cycle as a write-one clear or an acknowledge clear of the same flag, the flag is one after the edge.
- R6: `irq_req[b]` is one exactly when `gie`, `enables_rd[b]` and `flags_rd[b]` are all one.
- R7: `irq_valid` is one when any `irq_req` bit is one. `irq_idx` then equals 7-b, where b is the highest set bit of `irq_req`.
- R8: While `t2_dual_slope` is one, bit 6 is set only by `t2_turn_evt` and `evt_set[6]` is ignored. While it is zero, bit 6 is set only by `evt_set[6]` and `t2_turn_evt` is ignored.
- R9: A write with `reg_we`=1 and `reg_sel`=1 loads `reg_wdata` into the enable register, which reads back on `enables_rd`. Such a write leaves the flags unchanged.
- R10: A flag holds its value in every cycle that has no set event, no write-one clear and no acknowledge for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set | input | 8 | Per-flag set pulses from the timers, in flag bit order |
| t2_turn_evt | input | 1 | Timer-2 bottom turnaround pulse |
| t2_dual_slope | input | 1 | Timer 2 is running in dual-slope PWM mode |
| reg_we | input | 1 | Single-cycle register write strobe |
| reg_sel | input | 1 | Write target: 0 flag register, 1 enable register |
| reg_wdata | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| ack_valid | input | 1 | Vector acknowledge pulse |
| ack_idx | input | 3 | Index of the vector being acknowledged |
| flags_rd | output | 8 | Current flag register |
| enables_rd | output | 8 | Current enable register |
| irq_req | output | 8 | Per-source interrupt requests |
| irq_valid | output | 1 | A vector is being offered |
| irq_idx | output | 3 | Index of the offered vector |

## Verification
Each event bit is pulsed on its own, which shows that every source reaches its own flag and no other. The write-one clear is swept over all 256 masks with every flag set, which catches both a missed clear and a zero bit that wrongly clears. All 256 flag patterns are loaded with every source enabled to check the priority choice. All 256 enable masks are then tried with `gie` both low and high, which separates the effect of the enable register from the effect of the global gate. Separate sequences cover an acknowledge of each index, set-versus-clear collisions and both set sources of the timer-2 overflow flag in each mode.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int TIF_NSRC = 8;
  localparam int TIF_IDXW = $clog2(TIF_NSRC);

  // register select encoding on reg_sel
  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_ENABLE = 1'b1
  } tif_sel_e;

  // flag bit positions (decoded by software and by the vector map)
  localparam int BIT_T0_OVF  = 0;
  localparam int BIT_T0_CMP  = 1;
  localparam int BIT_T1_OVF  = 2;
  localparam int BIT_T1_CMPB = 3;
  localparam int BIT_T1_CMPA = 4;
  localparam int BIT_T1_CAP  = 5;
  localparam int BIT_T2_OVF  = 6;
  localparam int BIT_T2_CMP  = 7;
endpackage

// File: rtl/tif_set_mux.sv
module tif_set_mux #(
  parameter int NSRC     = 8,
  parameter int TURN_BIT = 6
) (
  input  logic [NSRC-1:0] evt_set,
  input  logic            turn_evt,
  input  logic            dual_slope,
  output logic [NSRC-1:0] set_eff
);
  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    if (b == TURN_BIT) begin : g_turn
      // dual-slope mode moves the set point to the bottom turnaround
      assign set_eff[b] = dual_slope ? turn_evt : evt_set[b];
    end else begin : g_plain
      assign set_eff[b] = evt_set[b];
    end
  end
endmodule

// File: rtl/tif_ack_decode.sv
module tif_ack_decode #(
  parameter int NSRC = 8,
  parameter int IDXW = 3
) (
  input  logic            ack_valid,
  input  logic [IDXW-1:0] ack_idx,
  output logic [NSRC-1:0] ack_mask
);
  // vector index i services flag bit NSRC-1-i
  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    localparam logic [IDXW-1:0] VEC = IDXW'(NSRC - 1 - b);
    assign ack_mask[b] = ack_valid && (ack_idx == VEC);
  end
endmodule

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_eff,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] hw_clr,
  output logic [NSRC-1:0] flags
);
  for (genvar b = 0; b < NSRC; b++) begin : g_cell
    logic nxt;
    // a set on the same cycle as any clear keeps the flag at one
    always_comb begin
      if (set_eff[b])                 nxt = 1'b1;
      else if (sw_clr[b] || hw_clr[b]) nxt = 1'b0;
      else                            nxt = flags[b];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[b] <= 1'b0;
      else        flags[b] <= nxt;
    end
  end
endmodule

// File: rtl/tif_prio_enc.sv
module tif_prio_enc #(
  parameter int NSRC = 8,
  parameter int IDXW = 3
) (
  input  logic [NSRC-1:0] req,
  output logic            valid,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    // later iterations override: the highest bit wins, giving index 0 top priority
    for (int b = 0; b < NSRC; b++) begin
      if (req[b]) begin
        valid = 1'b1;
        idx   = IDXW'(NSRC - 1 - b);
      end
    end
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tif_pkg::*;
#(
  parameter int NSRC     = TIF_NSRC,
  parameter int IDXW     = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int TURN_BIT = BIT_T2_OVF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_set,
  input  logic            t2_turn_evt,
  input  logic            t2_dual_slope,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [NSRC-1:0] reg_wdata,
  input  logic            gie,
  input  logic            ack_valid,
  input  logic [IDXW-1:0] ack_idx,
  output logic [NSRC-1:0] flags_rd,
  output logic [NSRC-1:0] enables_rd,
  output logic [NSRC-1:0] irq_req,
  output logic            irq_valid,
  output logic [IDXW-1:0] irq_idx
);
  logic [NSRC-1:0] set_eff;
  logic [NSRC-1:0] sw_clr;
  logic [NSRC-1:0] hw_clr;
  logic [NSRC-1:0] flags_q;
  logic [NSRC-1:0] en_q;
  logic            wr_flags;
  logic            wr_en;

  assign wr_flags = reg_we && (tif_sel_e'(reg_sel) == SEL_FLAGS);
  assign wr_en    = reg_we && (tif_sel_e'(reg_sel) == SEL_ENABLE);
  assign sw_clr   = wr_flags ? reg_wdata : '0;

  tif_set_mux #(.NSRC(NSRC), .TURN_BIT(TURN_BIT)) u_set (
    .evt_set    (evt_set),
    .turn_evt   (t2_turn_evt),
    .dual_slope (t2_dual_slope),
    .set_eff    (set_eff)
  );

  tif_ack_decode #(.NSRC(NSRC), .IDXW(IDXW)) u_ack (
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .ack_mask  (hw_clr)
  );

  tif_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_eff (set_eff),
    .sw_clr  (sw_clr),
    .hw_clr  (hw_clr),
    .flags   (flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= reg_wdata;
  end

  assign irq_req    = flags_q & en_q & {NSRC{gie}};
  assign flags_rd   = flags_q;
  assign enables_rd = en_q;

  tif_prio_enc #(.NSRC(NSRC), .IDXW(IDXW)) u_prio (
    .req   (irq_req),
    .valid (irq_valid),
    .idx   (irq_idx)
  );
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk #(
  parameter int NSRC     = 8,
  parameter int IDXW     = 3,
  parameter int TURN_BIT = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_set,
  input logic            t2_turn_evt,
  input logic            t2_dual_slope,
  input logic            reg_we,
  input logic            reg_sel,
  input logic [NSRC-1:0] reg_wdata,
  input logic            gie,
  input logic            ack_valid,
  input logic [IDXW-1:0] ack_idx,
  input logic [NSRC-1:0] flags_rd,
  input logic [NSRC-1:0] enables_rd,
  input logic [NSRC-1:0] irq_req,
  input logic            irq_valid,
  input logic [IDXW-1:0] irq_idx
);
  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    if (b != TURN_BIT) begin : g_plain
      AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[b] |=> flags_rd[b]); // R2
    end
    AST_REQ_NEEDS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[b] |-> (gie && enables_rd[b] && flags_rd[b])); // R6
    AST_ACK_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_idx == IDXW'(NSRC - 1 - b) && !evt_set[b] &&
       !(b == TURN_BIT && t2_turn_evt)) |=> !flags_rd[b]); // R4
  end

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set == '0 && !t2_turn_evt && !ack_valid && !reg_we) |=> $stable(flags_rd)); // R10
  AST_DUAL_IGNORES_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_dual_slope && !t2_turn_evt && !flags_rd[TURN_BIT]) |=> !flags_rd[TURN_BIT]); // R8
  AST_TURN_SETS_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_dual_slope && t2_turn_evt) |=> flags_rd[TURN_BIT]); // R8
  AST_VALID_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid == (irq_req != '0)); // R7
  AST_IDX_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_req[NSRC - 1 - int'(irq_idx)]); // R7
  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel) |=> enables_rd == $past(reg_wdata)); // R9
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.NSRC(NSRC), .IDXW(IDXW), .TURN_BIT(TURN_BIT)) u_chk (.*);

// File: tb/tmr_irq_flags_bench.sv
`timescale 1ns/1ps
module tmr_irq_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_set = '0;
  logic       t2_turn_evt = 1'b0;
  logic       t2_dual_slope = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       gie = 1'b0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_idx = '0;
  logic [7:0] flags_rd, enables_rd, irq_req;
  logic       irq_valid;
  logic [2:0] irq_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_irq_flags u_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .t2_turn_evt(t2_turn_evt),
    .t2_dual_slope(t2_dual_slope), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .gie(gie), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .flags_rd(flags_rd), .enables_rd(enables_rd), .irq_req(irq_req),
    .irq_valid(irq_valid), .irq_idx(irq_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock edge, then drop all pulse inputs; outputs are sampled 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
    evt_set = '0; t2_turn_evt = 1'b0; reg_we = 1'b0; ack_valid = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
  endtask

  task automatic load_flags(input logic [7:0] p);
    wr(1'b0, 8'hFF);
    evt_set = p;
    tick();
  endtask

  function automatic logic [3:0] exp_idx(input logic [7:0] r);
    exp_idx = 4'h8; // 8 means no request
    for (int b = 0; b < 8; b++) if (r[b]) exp_idx = 4'(7 - b);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12;
    // R1: reset state, with events arriving during reset
    evt_set = 8'hFF; gie = 1'b1;
    #10;
    chk("R1 flags", 32'(flags_rd), 0);
    chk("R1 enables", 32'(enables_rd), 0);
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 irq_valid", 32'(irq_valid), 0);
    evt_set = '0;
    @(negedge clk); rst_n = 1'b1;
    tick();

    // R2: each source sets only its own flag
    for (int b = 0; b < 8; b++) begin
      load_flags(8'(1 << b));
      chk("R2 single event", 32'(flags_rd), 32'(1 << b));
    end

    // R10: flags hold with no activity
    load_flags(8'hA5);
    repeat (5) tick();
    chk("R10 hold", 32'(flags_rd), 32'hA5);

    // R3: write-one clear, all masks
    for (int m = 0; m < 256; m++) begin
      load_flags(8'hFF);
      wr(1'b0, 8'(m));
      chk("R3 w1c", 32'(flags_rd), 32'(~m & 8'hFF));
    end

    // R9: enable write and readback, flags untouched
    load_flags(8'h3C);
    wr(1'b1, 8'h96);
    chk("R9 enable readback", 32'(enables_rd), 32'h96);
    chk("R9 flags untouched", 32'(flags_rd), 32'h3C);

    // R7: priority over all flag patterns, everything enabled
    wr(1'b1, 8'hFF);
    gie = 1'b1;
    for (int p = 0; p < 256; p++) begin
      load_flags(8'(p));
      chk("R7 valid", 32'(irq_valid), 32'(p != 0));
      if (p != 0) chk("R7 index", 32'(irq_idx), 32'(exp_idx(8'(p))));
    end

    // R6: request gating over all enable masks and both gie values
    load_flags(8'hFF);
    for (int e = 0; e < 256; e++) begin
      wr(1'b1, 8'(e));
      for (int g = 0; g < 2; g++) begin
        gie = g[0];
        #1;
        chk("R6 request", 32'(irq_req), g ? 32'(e) : 0);
      end
    end
    load_flags(8'h5A);
    wr(1'b1, 8'hF0);
    gie = 1'b1; #1;
    chk("R6 partial", 32'(irq_req), 32'h50);

    // R4: acknowledge clears only the matching flag
    for (int i = 0; i < 8; i++) begin
      load_flags(8'hFF);
      ack_valid = 1'b1; ack_idx = 3'(i);
      tick();
      chk("R4 ack", 32'(flags_rd), 32'(8'hFF & ~(8'h80 >> i)));
    end
    load_flags(8'h00);
    ack_valid = 1'b1; ack_idx = 3'd2;
    tick();
    chk("R4 ack on clear flag", 32'(flags_rd), 0);

    // R5: set beats a clear in the same cycle
    load_flags(8'h00);
    evt_set = 8'h81; reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hFF;
    tick();
    chk("R5 set vs w1c", 32'(flags_rd), 32'h81);
    evt_set = 8'h01; ack_valid = 1'b1; ack_idx = 3'd7;
    tick();
    chk("R5 set vs ack", 32'(flags_rd), 32'h81);

    // R8: timer-2 overflow set source by mode
    t2_dual_slope = 1'b1;
    load_flags(8'h40);
    chk("R8 dual ignores wrap", 32'(flags_rd), 0);
    t2_turn_evt = 1'b1;
    tick();
    chk("R8 dual turn sets", 32'(flags_rd), 32'h40);
    t2_dual_slope = 1'b0;
    wr(1'b0, 8'hFF);
    t2_turn_evt = 1'b1;
    tick();
    chk("R8 normal ignores turn", 32'(flags_rd), 0);
    evt_set = 8'h40;
    tick();
    chk("R8 normal wrap sets", 32'(flags_rd), 32'h40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule